// File: doc/BRIEF.md
# D-channel access collision controller

This block is the layer-1 half of shared D-channel access on a basic-rate S bus. Layer 2 hands it one D bit per D-bit slot. The block puts that bit on the line only after it has won the bus. While it waits, it drives idle ones and counts consecutive echo ones. When the count reaches the threshold of the active priority class, the next layer-2 bit goes out. From then on, every echo bit returned by the network is compared with the bit just sent. On any mismatch, transmission stops at once: the line returns to ones and counting starts again.

The outcome is reported to layer 2 as a Stop/Go bit. This bit is refreshed only at one position of the 96-bit multiplexed frame. It is lowered one frame ahead of the bus becoming free, so the first layer-2 zeros arrive just as access opens. A layer-2 end-of-frame flag ends a transmission. After a successful frame, the threshold is raised by one for the following attempt. Only two mode-field codes enable arbitration. In every other mode the D bits pass straight through.

Top module: `dch_access_ctrl`

## Requirements
- R1: In the arbitrating state, a D-slot strobe whose echo_i differs from the bit on d_o is a collision, in either polarity. d_o becomes 1 on the next cycle and stays 1, and echo counting restarts from zero.
- R2: While waiting, each strobe with echo_i=1 advances a count, and a strobe with echo_i=0 clears it. On the strobe that brings the count to the threshold, d_o takes l2_d_i and the block starts transmitting.
- R3: cls_cmd_valid_i with cls_cmd_hi_i=1 selects the 10-ones class, and with cls_cmd_hi_i=0 it selects the 8-ones class. A new class takes effect only once counting is at zero; it never changes an attempt that is already in progress.
- R4: A frame that ends without a collision raises the threshold by one for the next attempt (8 to 9, 10 to 11). The base threshold returns once that raised count has been reached.
- R5: A strobe with l2_eof_i=1 and no collision ends transmission. d_o returns to 1 and counting restarts.
- R6: In arbitrating modes, sg_o changes only on the cycle after frm_bit_i equals 90.
- R7: At that position, sg_o is loaded with 0 if the block is transmitting or if count + 2 >= threshold. Otherwise it is loaded with 1.
- R8: Only mode_i = 3'b001 or 3'b011 arbitrates. In any other mode, d_o takes l2_d_i at each strobe regardless of the echo, sg_o is 0, and the count is cleared.
- R9: Reset (rst_ni low) sets d_o=1 and sg_o=1, clears the count and selects the 8-ones class without any raise.
- R10: d_o changes only on a cycle after a D-slot strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Mode field; 001 and 011 arbitrate |
| cls_cmd_valid_i | input | 1 | Priority-class command strobe |
| cls_cmd_hi_i | input | 1 | 1: 10-ones class, 0: 8-ones class |
| dslot_i | input | 1 | D-bit slot strobe, one cycle |
| echo_i | input | 1 | Echo bit for the current slot |
| l2_d_i | input | 1 | Next D bit from layer 2 |
| l2_eof_i | input | 1 | Layer-2 end of frame, marks the bit on the line as the last |
| frm_bit_i | input | 7 | Bit position in the 96-bit multiplexed frame |
| d_o | output | 1 | D bit toward the line |
| sg_o | output | 1 | Stop/Go bit, 1 busy, 0 go |

## Verification
The hardest case to reach is a class change that arrives partway through a count. The new class must not touch the attempt in progress and must apply from the next one. To reach it, the bench first wins the bus, then forces a collision and counts a few echo ones. It issues the opposite class command at that point and continues to a count that would have granted under the new class. It then clears the count with an echo zero and checks that the grant now comes at the new threshold. The raised threshold after a clean end of frame is reached the same way: the bench ends one frame and counts to one below the raised value.

// File: rtl/dch_pkg.sv
package dch_pkg;
  typedef enum logic {ST_CNT = 1'b0, ST_TX = 1'b1} arb_st_e;
endpackage

// File: rtl/dch_thresh.sv
module dch_thresh #(
  parameter int CNT_W = 4,
  parameter int LO    = 8,
  parameter int HI    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic             cmd_hi_i,
  input  logic             cnt_zero_i,
  input  logic             success_i,
  input  logic             grant_i,
  output logic [CNT_W-1:0] thr_o
);
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI);

  logic cls_req_q, cls_act_q, raised_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_req_q <= 1'b0;
      cls_act_q <= 1'b0;
      raised_q  <= 1'b0;
    end else begin
      if (cmd_valid_i) cls_req_q <= cmd_hi_i;
      // class switches only between attempts
      if (cnt_zero_i) cls_act_q <= cls_req_q;
      if (success_i)    raised_q <= 1'b1;
      else if (grant_i) raised_q <= 1'b0;
    end
  end

  assign thr_o = (cls_act_q ? HI_C : LO_C) + CNT_W'(raised_q);
endmodule

// File: rtl/dch_arbiter.sv
module dch_arbiter
  import dch_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             slot_i,
  input  logic             echo_i,
  input  logic             l2_d_i,
  input  logic             l2_eof_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             d_o,
  output arb_st_e          st_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             grant_o,
  output logic             success_o
);
  localparam int CW1 = CNT_W + 1;

  arb_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             d_q;
  logic [CW1-1:0]   cnt_inc;
  logic             mism, coll;

  always_comb begin
    cnt_inc   = {1'b0, cnt_q} + CW1'(1);
    mism      = echo_i != d_q;
    grant_o   = en_i && slot_i && (st_q == ST_CNT) && echo_i && (cnt_inc >= {1'b0, thr_i});
    coll      = en_i && slot_i && (st_q == ST_TX) && mism;
    success_o = en_i && slot_i && (st_q == ST_TX) && !mism && l2_eof_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_CNT;
      cnt_q <= '0;
      d_q   <= 1'b1;
    end else if (!en_i) begin
      st_q  <= ST_CNT;
      cnt_q <= '0;
      if (slot_i) d_q <= l2_d_i;
    end else if (slot_i) begin
      unique case (st_q)
        ST_CNT: begin
          if (grant_o) begin
            st_q  <= ST_TX;
            cnt_q <= '0;
            d_q   <= l2_d_i;
          end else begin
            cnt_q <= echo_i ? cnt_inc[CNT_W-1:0] : '0;
            d_q   <= 1'b1;
          end
        end
        ST_TX: begin
          if (coll || success_o) begin
            st_q  <= ST_CNT;
            cnt_q <= '0;
            d_q   <= 1'b1;
          end else begin
            d_q <= l2_d_i;
          end
        end
        default: st_q <= ST_CNT;
      endcase
    end
  end

  assign d_o   = d_q;
  assign st_o  = st_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/dch_sg.sv
module dch_sg
  import dch_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int FBIT_W = 7,
  parameter int SG_POS = 90,
  parameter int LEAD   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FBIT_W-1:0] frm_bit_i,
  input  arb_st_e           st_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  thr_i,
  output logic              sg_o
);
  localparam int CW1 = CNT_W + 1;

  logic go, sg_q;

  // go one frame ahead: LEAD = D slots per multiplexed frame
  assign go = (st_i == ST_TX) || (({1'b0, cnt_i} + CW1'(LEAD)) >= {1'b0, thr_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          sg_q <= 1'b1;
    else if (!en_i)                       sg_q <= 1'b0;
    else if (frm_bit_i == FBIT_W'(SG_POS)) sg_q <= !go;
  end

  assign sg_o = sg_q;
endmodule

// File: rtl/dch_access_ctrl.sv
module dch_access_ctrl
  import dch_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int CLS_LO   = 8,
  parameter int CLS_HI   = 10,
  parameter int FRM_BITS = 96,
  parameter int SG_POS   = 90,
  parameter int LEAD     = 2,
  localparam int FBIT_W  = $clog2(FRM_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              cls_cmd_valid_i,
  input  logic              cls_cmd_hi_i,
  input  logic              dslot_i,
  input  logic              echo_i,
  input  logic              l2_d_i,
  input  logic              l2_eof_i,
  input  logic [FBIT_W-1:0] frm_bit_i,
  output logic              d_o,
  output logic              sg_o
);
  logic             arb_en;
  arb_st_e          arb_st;
  logic [CNT_W-1:0] arb_cnt, thr;
  logic             grant, success;

  assign arb_en = (mode_i == 3'b001) || (mode_i == 3'b011);

  dch_thresh #(.CNT_W(CNT_W), .LO(CLS_LO), .HI(CLS_HI)) u_thresh (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cls_cmd_valid_i),
    .cmd_hi_i   (cls_cmd_hi_i),
    .cnt_zero_i ((arb_st == ST_CNT) && (arb_cnt == '0)),
    .success_i  (success),
    .grant_i    (grant),
    .thr_o      (thr)
  );

  dch_arbiter #(.CNT_W(CNT_W)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (arb_en),
    .slot_i   (dslot_i),
    .echo_i   (echo_i),
    .l2_d_i   (l2_d_i),
    .l2_eof_i (l2_eof_i),
    .thr_i    (thr),
    .d_o      (d_o),
    .st_o     (arb_st),
    .cnt_o    (arb_cnt),
    .grant_o  (grant),
    .success_o(success)
  );

  dch_sg #(.CNT_W(CNT_W), .FBIT_W(FBIT_W), .SG_POS(SG_POS), .LEAD(LEAD)) u_sg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (arb_en),
    .frm_bit_i(frm_bit_i),
    .st_i     (arb_st),
    .cnt_i    (arb_cnt),
    .thr_i    (thr),
    .sg_o     (sg_o)
  );
endmodule

// File: rtl/dch_access_ctrl_chk.sv
module dch_access_ctrl_chk
  import dch_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int FBIT_W = 7,
  parameter int SG_POS = 90
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              slot_i,
  input logic              echo_i,
  input logic              l2_d_i,
  input logic              l2_eof_i,
  input logic [FBIT_W-1:0] frm_bit_i,
  input logic              d_o,
  input logic              sg_o,
  input arb_st_e           st_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  thr_i
);
  a_r1_collision_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && slot_i && st_i == ST_TX && echo_i != d_o) |=> (d_o && st_i == ST_CNT));

  a_r5_eof_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && slot_i && st_i == ST_TX && echo_i == d_o && l2_eof_i) |=> (d_o && st_i == ST_CNT));

  a_r2_cnt_below_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i < thr_i);

  a_r2_wait_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && slot_i && st_i == ST_CNT) |=> (d_o || st_i == ST_TX));

  a_r6_sg_fixed_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && frm_bit_i != FBIT_W'(SG_POS)) |=> $stable(sg_o));

  a_r8_transp_sg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sg_o);

  a_r8_transp_d: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && slot_i) |=> d_o == $past(l2_d_i));

  a_r10_d_on_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> $stable(d_o));
endmodule

bind dch_access_ctrl dch_access_ctrl_chk #(
  .CNT_W (CNT_W),
  .FBIT_W(FBIT_W),
  .SG_POS(SG_POS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (arb_en),
  .slot_i   (dslot_i),
  .echo_i   (echo_i),
  .l2_d_i   (l2_d_i),
  .l2_eof_i (l2_eof_i),
  .frm_bit_i(frm_bit_i),
  .d_o      (d_o),
  .sg_o     (sg_o),
  .st_i     (arb_st),
  .cnt_i    (arb_cnt),
  .thr_i    (thr)
);

// File: tb/dch_access_ctrl_bench.sv
`timescale 1ns/1ps
module dch_access_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] mode = 3'b001;
  logic       cmd_v = 1'b0, cmd_hi = 1'b0;
  logic       dslot = 1'b0, echo = 1'b1, l2d = 1'b1, eof = 1'b0;
  logic [6:0] frm = 7'd0;
  logic       d_o, sg_o;
  int         n_chk = 0, n_fail = 0, cyc = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  dch_access_ctrl u_dch_access_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .cls_cmd_valid_i(cmd_v), .cls_cmd_hi_i(cmd_hi),
    .dslot_i(dslot), .echo_i(echo), .l2_d_i(l2d), .l2_eof_i(eof),
    .frm_bit_i(frm), .d_o(d_o), .sg_o(sg_o)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      summary();
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic slot(input logic e, input logic d, input logic f);
    @(negedge clk); echo = e; l2d = d; eof = f; dslot = 1'b1;
    @(negedge clk); dslot = 1'b0; eof = 1'b0;
  endtask

  task automatic sg_pulse();
    @(negedge clk); frm = 7'd90;
    @(negedge clk); frm = 7'd0;
  endtask

  task automatic cls_cmd(input logic hi);
    @(negedge clk); cmd_v = 1'b1; cmd_hi = hi;
    @(negedge clk); cmd_v = 1'b0;
  endtask

  // n echo ones, checking that the grant lands on strobe thr (l2d=0 then)
  task automatic count_to(input int n, input int thr, input string tag);
    for (int i = 1; i <= n; i++) begin
      slot(1'b1, 1'b0, 1'b0);
      chk(d_o, (i >= thr) ? 1'b0 : 1'b1, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(d_o, 1'b1, "R9 d_o reset");
    chk(sg_o, 1'b1, "R9 sg_o reset");
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 / R9: 8-ones class after reset
    count_to(8, 8, "R2 grant at 8");
    sg_pulse();
    chk(sg_o, 1'b0, "R7 go while transmitting");
    // R1: echo 1 against sent 0
    slot(1'b1, 1'b0, 1'b0);
    chk(d_o, 1'b1, "R1 collision echo1/sent0");
    slot(1'b1, 1'b0, 1'b0);
    chk(d_o, 1'b1, "R1 idle after collision");
    sg_pulse();
    chk(sg_o, 1'b1, "R7 busy at count 1");
    // R2: zero clears count
    count_to(4, 99, "R2 counting");
    slot(1'b0, 1'b0, 1'b0);
    chk(d_o, 1'b1, "R2 echo zero");
    count_to(5, 99, "R2 recount");
    sg_pulse();
    chk(sg_o, 1'b1, "R7 busy at count 5");
    slot(1'b1, 1'b0, 1'b0);
    sg_pulse();
    chk(sg_o, 1'b0, "R7 early go at count 6");
    slot(1'b1, 1'b0, 1'b0);
    chk(d_o, 1'b1, "R2 count 7 still idle");
    slot(1'b1, 1'b0, 1'b0);
    chk(d_o, 1'b0, "R2 grant after cleared count");
    // R1: echo 0 against sent 1
    slot(1'b0, 1'b1, 1'b0);
    chk(d_o, 1'b1, "R2 transmit bit 1");
    slot(1'b0, 1'b0, 1'b0);
    chk(d_o, 1'b1, "R1 collision echo0/sent1");
    repeat (3) @(negedge clk);
    chk(sg_o, 1'b0, "R6 sg held off position 90");
    sg_pulse();
    chk(sg_o, 1'b1, "R6 sg refreshed at 90");

    // R5 / R4: clean end of frame raises threshold to 9
    count_to(8, 8, "R2 grant for frame");
    slot(1'b0, 1'b1, 1'b0);
    slot(1'b1, 1'b0, 1'b1);
    chk(d_o, 1'b1, "R5 release after eof");
    count_to(9, 9, "R4 raised threshold 9");
    slot(1'b1, 1'b0, 1'b0);
    chk(d_o, 1'b1, "R1 collision after raised grant");
    count_to(8, 8, "R4 base threshold restored");

    // R3: 10-ones class
    cls_cmd(1'b1);
    slot(1'b1, 1'b0, 1'b0);
    chk(d_o, 1'b1, "R1 collision before class test");
    count_to(10, 10, "R3 grant at 10");
    slot(1'b1, 1'b0, 1'b0);
    count_to(3, 99, "R3 partial count");
    cls_cmd(1'b0);
    count_to(5, 99, "R3 class kept mid attempt");
    slot(1'b0, 1'b0, 1'b0);
    count_to(8, 8, "R3 new class after restart");

    // R8: sweep all mode codes from a transparent baseline
    for (int m = 0; m < 8; m++) begin
      logic en;
      en = (m == 1) || (m == 3);
      @(negedge clk); mode = 3'b000;
      slot(1'b0, 1'b1, 1'b0);
      chk(d_o, 1'b1, "R8 transparent bit 1");
      slot(1'b1, 1'b0, 1'b0);
      chk(d_o, 1'b0, "R8 transparent echo ignored");
      chk(sg_o, 1'b0, "R8 transparent sg low");
      @(negedge clk); mode = 3'(m);
      slot(1'b1, 1'b0, 1'b0);
      chk(d_o, en ? 1'b1 : 1'b0, "R8 mode decides arbitration");
      sg_pulse();
      chk(sg_o, en ? 1'b1 : 1'b0, "R8 mode decides sg");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule